// File: doc/BRIEF.md
# Stalling Wide-Word ISA Read Bridge

This block lets a host with an 8-bit data bus read a 16-bit location on an ISA bus. When the host reads the mapped low-byte address while wide mode is selected, the bridge pulls the host's ready line low. While the host waits, the bridge runs an ISA read strobe for a set number of clocks and captures the whole 16-bit word. It then raises ready again, and the host completes its read with the low byte. The high byte stays in a holding register. The host fetches it later from a separate high-byte address, and that fetch starts no new bus cycle.

In narrow mode the holding register is bypassed. A host read or write becomes one plain single-byte ISA cycle in the same clock, so 8-bit peripherals never see an extra access. Writes never stall in either mode. Address decoding happens outside the block and arrives as a select strobe plus a high-byte flag.

The host side works like a valid/ready pair. `host_sel` is the valid signal and `host_rdy` is the ready signal. The host holds `host_sel`, `host_we`, `host_hi` and `host_wdata` steady while `host_rdy` is low. The access completes in the first cycle in which `host_sel` and `host_rdy` are both high. A new access may follow in the next cycle.

Top module: `isa_wide_read_bridge`

## Requirements
- R1: After reset, `host_rdy` is 1, `isa_ior_n` and `isa_iow_n` are 1, and a high-byte read returns 0x00.
- R2: A wide-mode read of the low-byte address (`host_sel`=1, `host_we`=0, `host_hi`=0, `wide_mode`=1) drives `host_rdy` low in its request cycle. `host_rdy` stays low for exactly HOLD_CYCLES+1 cycles in total.
- R3: During that stall, `isa_ior_n` is high in the request cycle. It is then low for exactly HOLD_CYCLES consecutive cycles (default 2), and high again when `host_rdy` returns.
- R4: In the completion cycle, `host_rdata` equals bits 7:0 of `isa_rdata` as sampled on the last strobe cycle, even if the bus data has changed since.
- R5: A read with `host_hi`=1 returns bits 15:8 of the last captured word, with `host_rdy` high and no ISA strobe, in either mode.
- R6: A narrow-mode low-byte read (`wide_mode`=0) never stalls. It drives `isa_ior_n` low in the same cycle and returns `isa_rdata[7:0]` combinationally.
- R7: A low-byte write in either mode never stalls. It drives `isa_iow_n` low in the same cycle with `isa_wdata` = `host_wdata`, and `isa_ior_n` stays high.
- R8: Narrow-mode reads do not change the held high byte.
- R9: A write with `host_hi`=1 has no effect: there is no strobe, `host_rdy` stays high, and the held high byte is unchanged.
- R10: `isa_ior_n` and `isa_iow_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 = 16-bit stalled reads, 0 = plain 8-bit cycles |
| host_sel | input | 1 | Host access valid (window decoded) |
| host_we | input | 1 | 1 = write, 0 = read |
| host_hi | input | 1 | 1 = high-byte holding register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdy | output | 1 | Ready to host CPU; low stalls it |
| isa_ior_n | output | 1 | ISA I/O read strobe, active low |
| isa_iow_n | output | 1 | ISA I/O write strobe, active low |
| isa_rdata | input | 16 | ISA data bus in |
| isa_wdata | output | 8 | ISA low data byte out |

## Verification
Plain cycles and high-byte reads respond within the same cycle as the request. The bench therefore sets inputs on the falling edge and samples one time unit later.

A wide read drops ready in its request cycle. The strobe then runs for HOLD_CYCLES cycles, one per edge, and the data appears in cycle HOLD_CYCLES+1 after the request. The bench steps one falling edge at a time and checks ready, the strobe and the data in each of those cycles. It also changes the bus data just before the completion sample, which proves the byte comes from the capture edge.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_STROBE = 2'd1,
    SEQ_DONE   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/isa_read_sequencer.sv
module isa_read_sequencer
  import isa_bridge_pkg::*;
#(
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic strobe_on,
  output logic capture,
  output logic done
);
  localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  seq_state_t state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_STROBE;
          cnt_q   <= '0;
        end
        SEQ_STROBE: begin
          if (cnt_q == LAST) state_q <= SEQ_DONE;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        SEQ_DONE: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == SEQ_IDLE);
  assign strobe_on = (state_q == SEQ_STROBE);
  assign capture   = strobe_on && (cnt_q == LAST);
  assign done      = (state_q == SEQ_DONE);

  // R3: a strobe run always ends in the completion state
  assert_strobe_to_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> done);
endmodule

// File: rtl/isa_word_latch.sv
module isa_word_latch #(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WORD_W-1:0]   word_in,
  output logic [WORD_W/2-1:0] lo_q,
  output logic [WORD_W/2-1:0] hi_q
);
  localparam int HALF = WORD_W / 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= word_in[HALF-1:0];
      hi_q <= word_in[WORD_W-1:HALF];
    end
  end

  // R8, R9: the held byte moves only on a capture
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hi_q));
endmodule

// File: rtl/host_read_mux.sv
module host_read_mux #(
  parameter int BYTE_W = 8
) (
  input  logic              sel_hi,
  input  logic              sel_done,
  input  logic [BYTE_W-1:0] held_hi,
  input  logic [BYTE_W-1:0] held_lo,
  input  logic [BYTE_W-1:0] bus_lo,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    if (sel_hi)        rdata = held_hi;
    else if (sel_done) rdata = held_lo;
    else               rdata = bus_lo;
  end
endmodule

// File: rtl/isa_wide_read_bridge.sv
module isa_wide_read_bridge #(
  parameter int ISA_W       = 16,
  parameter int HOLD_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_mode,
  input  logic               host_sel,
  input  logic               host_we,
  input  logic               host_hi,
  input  logic [ISA_W/2-1:0] host_wdata,
  output logic [ISA_W/2-1:0] host_rdata,
  output logic               host_rdy,
  output logic               isa_ior_n,
  output logic               isa_iow_n,
  input  logic [ISA_W-1:0]   isa_rdata,
  output logic [ISA_W/2-1:0] isa_wdata
);
  localparam int HOST_W = ISA_W / 2;
  localparam int MON_W  = $clog2(HOLD_CYCLES + 2);

  logic seq_idle, strobe_on, capture, seq_done;
  logic start_wide, plain_rd, plain_wr;
  logic [HOST_W-1:0] held_lo, held_hi;

  assign start_wide = seq_idle && host_sel && !host_we && !host_hi && wide_mode;
  assign plain_rd   = seq_idle && host_sel && !host_we && !host_hi && !wide_mode;
  assign plain_wr   = seq_idle && host_sel && host_we && !host_hi;

  isa_read_sequencer #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_wide),
    .idle(seq_idle), .strobe_on(strobe_on), .capture(capture), .done(seq_done)
  );

  isa_word_latch #(.WORD_W(ISA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(capture), .word_in(isa_rdata),
    .lo_q(held_lo), .hi_q(held_hi)
  );

  host_read_mux #(.BYTE_W(HOST_W)) u_mux (
    .sel_hi(host_hi), .sel_done(seq_done), .held_hi(held_hi),
    .held_lo(held_lo), .bus_lo(isa_rdata[HOST_W-1:0]), .rdata(host_rdata)
  );

  assign host_rdy  = !(start_wide || strobe_on);
  assign isa_ior_n = !(strobe_on || plain_rd);
  assign isa_iow_n = !plain_wr;
  assign isa_wdata = host_wdata;

  // Checker state: length of the strobe run inside a stall
  logic [MON_W-1:0] stall_strb_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) stall_strb_cnt <= '0;
    else if (!isa_ior_n && !host_rdy) stall_strb_cnt <= stall_strb_cnt + 1'b1;
    else stall_strb_cnt <= '0;
  end

  assert_strobe_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rdy) |-> (stall_strb_cnt == MON_W'(HOLD_CYCLES)));
  assert_low_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_rdy) && host_sel && !host_hi) |->
      (host_rdata == $past(isa_rdata[HOST_W-1:0])));
  assert_hi_no_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_hi) |-> (isa_ior_n && isa_iow_n && host_rdy));
  assert_plain_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_we && !host_hi && !wide_mode) |-> (!isa_ior_n && host_rdy));
  assert_write_nostall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_we) |-> (host_rdy && isa_ior_n));
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!isa_ior_n && !isa_iow_n));
endmodule

// File: tb/tb_isa_wide_read_bridge.sv
module tb_isa_wide_read_bridge;
  localparam int PERIOD = 10;
  localparam int HOLD   = 2;
  localparam int LIMIT  = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0, host_sel = 1'b0, host_we = 1'b0, host_hi = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata, isa_wdata;
  logic host_rdy, isa_ior_n, isa_iow_n;
  logic [15:0] isa_rdata = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(PERIOD/2) clk = ~clk;

  isa_wide_read_bridge #(.ISA_W(16), .HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .host_sel(host_sel),
    .host_we(host_we), .host_hi(host_hi), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rdy(host_rdy), .isa_ior_n(isa_ior_n),
    .isa_iow_n(isa_iow_n), .isa_rdata(isa_rdata), .isa_wdata(isa_wdata)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0; host_hi = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(host_rdy == 1'b1, "R1 rdy", host_rdy, 1);
    check(isa_ior_n == 1'b1 && isa_iow_n == 1'b1, "R1 strobes", {isa_ior_n, isa_iow_n}, 3);
  endtask

  task automatic t_read_hi(input logic [7:0] exp, input string req);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_hi = 1'b1; isa_rdata = 16'hDEAD;
    #1;
    check(host_rdata == exp, req, host_rdata, exp);
    check(host_rdy && isa_ior_n && isa_iow_n, "R5 no cycle", {host_rdy, isa_ior_n, isa_iow_n}, 7);
    idle_bus();
  endtask

  task automatic t_read_wide(input logic [15:0] word);
    @(negedge clk);
    wide_mode = 1'b1; isa_rdata = word;
    host_sel = 1'b1; host_we = 1'b0; host_hi = 1'b0;
    #1;
    check(host_rdy == 1'b0, "R2 rdy low in request cycle", host_rdy, 0);
    check(isa_ior_n == 1'b1, "R3 no strobe in request cycle", isa_ior_n, 1);
    for (int i = 0; i < HOLD; i++) begin
      @(negedge clk); #1;
      check(host_rdy == 1'b0, "R2 rdy held low", host_rdy, 0);
      check(isa_ior_n == 1'b0, "R3 strobe low", isa_ior_n, 0);
    end
    @(negedge clk);
    isa_rdata = ~word;
    #1;
    check(host_rdy == 1'b1, "R2 rdy released", host_rdy, 1);
    check(isa_ior_n == 1'b1, "R3 strobe released", isa_ior_n, 1);
    check(host_rdata == word[7:0], "R4 low byte", host_rdata, word[7:0]);
    idle_bus();
  endtask

  task automatic t_read_narrow(input logic [15:0] word);
    @(negedge clk);
    wide_mode = 1'b0; isa_rdata = word;
    host_sel = 1'b1; host_we = 1'b0; host_hi = 1'b0;
    #1;
    check(host_rdy == 1'b1, "R6 no stall", host_rdy, 1);
    check(isa_ior_n == 1'b0, "R6 strobe same cycle", isa_ior_n, 0);
    check(host_rdata == word[7:0], "R6 data", host_rdata, word[7:0]);
    idle_bus();
    #1;
    check(isa_ior_n == 1'b1, "R6 single cycle", isa_ior_n, 1);
  endtask

  task automatic t_write(input logic mode, input logic [7:0] d);
    @(negedge clk);
    wide_mode = mode;
    host_sel = 1'b1; host_we = 1'b1; host_hi = 1'b0; host_wdata = d;
    #1;
    check(host_rdy == 1'b1, "R7 no stall", host_rdy, 1);
    check(isa_iow_n == 1'b0 && isa_ior_n == 1'b1, "R7 strobes", {isa_iow_n, isa_ior_n}, 1);
    check(isa_wdata == d, "R7 data", isa_wdata, d);
    idle_bus();
    #1;
    check(isa_iow_n == 1'b1 && host_rdy == 1'b1, "R7 one cycle", {isa_iow_n, host_rdy}, 3);
  endtask

  task automatic t_write_hi(input logic [7:0] d);
    @(negedge clk);
    wide_mode = 1'b1;
    host_sel = 1'b1; host_we = 1'b1; host_hi = 1'b1; host_wdata = d;
    #1;
    check(host_rdy && isa_iow_n && isa_ior_n, "R9 ignored", {host_rdy, isa_iow_n, isa_ior_n}, 7);
    idle_bus();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!isa_ior_n && !isa_iow_n) begin
      total++; bad++;
      $display("FAIL R10 both strobes low actual=0 expected=1");
    end
    if (cyc > LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_read_hi(8'h00, "R1 held byte clear");
    t_read_wide(16'hA55A);
    t_read_hi(8'hA5, "R5 high byte");
    t_read_hi(8'hA5, "R5 repeat high byte");
    t_read_narrow(16'h1234);
    t_read_hi(8'hA5, "R8 held after narrow read");
    t_write(1'b0, 8'h3C);
    t_write(1'b1, 8'hC3);
    t_write_hi(8'h77);
    t_read_hi(8'hA5, "R9 held after high write");
    t_read_wide(16'hFF01);
    t_read_hi(8'hFF, "R5 second word");
    t_read_wide(16'h0080);
    t_read_hi(8'h00, "R5 zero high byte");
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule